// File: doc/BRIEF.md
# Pipelined Burst Memory with Dual Address Strobes

This block is a single-clock on-chip memory with a burst-SRAM style front end. An access starts when one of two active-low address strobes is taken. One strobe belongs to a processor and one to a controller. The presented address is then latched. Its two lowest bits seed a 2-bit beat counter, and an active-low advance input steps that counter through a four-beat linear burst that wraps. The effective address is the latched upper bits joined with the beat counter.

Reads are registered. The value on the read bus is the word at the address selected one rising edge earlier. An output-enable input decides whether that value is presented, and a valid flag stands in for the high-impedance state. Writes are taken with a controller strobe or an advance. A sleep input freezes the front end while keeping the stored words intact.

Top module: `burst_sram`

## Requirements
- R1: With chip enable active (`ce_n` low), a low `cpu_stb_n` at a rising edge selects `addr` as the effective address. A processor-strobe cycle never writes, whatever `we_n` is.
- R2: A low `ctl_stb_n` at a rising edge selects `addr` as the effective address whatever the level of `ce_n`, unless a processor strobe is taken at that edge.
- R3: If both strobes are low and `ce_n` is low, only the processor strobe acts, so `we_n` low causes no write at that edge.
- R4: With `ce_n` high, a low `cpu_stb_n` is ignored. The effective address holds unless the controller strobe or an advance acts.
- R5: With no strobe taken and `adv_n` low, address bits 1:0 step by one modulo 4 and the upper bits hold. Five beats from offset k come back to offset k+1.
- R6: The read register loads, at every awake rising edge, the word at the effective address that was in force before that edge. Data for a selected address therefore appears after the next edge.
- R7: With `we_n` low, a controller-strobe or advance edge stores `wdata` at the address that edge selects. An edge with no strobe and no advance writes nothing.
- R8: `rdata_vld` is high exactly when `oe_n` is low and `sleep` is low. While `rdata_vld` is low, `rdata` reads zero.
- R9: While `sleep` is high, strobes, advances and writes are ignored. The effective address, the read register and the memory contents hold. Normal operation resumes at the first edge after `sleep` falls.
- R10: After reset, the effective address is 0 and the read register holds zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_stb_n | input | 1 | Processor address strobe, active low, gated by chip enable |
| ctl_stb_n | input | 1 | Controller address strobe, active low |
| ce_n | input | 1 | Chip enable, active low |
| adv_n | input | 1 | Burst advance, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| sleep | input | 1 | Sleep request, active high |
| addr | input | AW | Word address |
| wdata | input | DW | Write data |
| rdata | output | DW | Registered read data, zero when not valid |
| rdata_vld | output | 1 | Read data presented (stands in for driven outputs) |

## Verification
An address selection and a write both take effect at the rising edge where the strobe or advance is sampled. The matching read word reaches `rdata` one edge later, because the read register loads the word at the address in force before each edge. `rdata_vld` follows `oe_n` and `sleep` with no clock delay. The bench drives every command at a falling edge, updates its model of the memory, the address and the read register at the following rising edge, and compares the outputs 1 ns after that edge. The pipeline delay is therefore counted in the model rather than assumed in the check.

// File: rtl/burst_sram.sv
module burst_sram #(
  parameter int AW = 6,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpu_stb_n,
  input  logic          ctl_stb_n,
  input  logic          ce_n,
  input  logic          adv_n,
  input  logic          we_n,
  input  logic          oe_n,
  input  logic          sleep,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          rdata_vld
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];
  logic [AW-3:0] base_q;
  logic [1:0]    beat_q;
  logic [DW-1:0] rd_q;
  logic [AW-1:0] eff, nxt;

  wire awake   = !sleep;
  wire cpu_hit = awake && !cpu_stb_n && !ce_n;
  wire ctl_hit = awake && !ctl_stb_n && !cpu_hit;
  wire step    = awake && !cpu_hit && !ctl_hit && !adv_n;
  wire wr_go   = !we_n && (ctl_hit || step);

  assign eff = {base_q, beat_q};
  assign nxt = (cpu_hit || ctl_hit) ? addr :
               step ? {base_q, beat_q + 2'd1} : eff;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      beat_q <= '0;
      rd_q   <= '0;
    end else if (awake) begin
      {base_q, beat_q} <= nxt;
      rd_q <= mem[eff];
    end
  end

  always_ff @(posedge clk)
    if (wr_go) mem[nxt] <= wdata;

  assign rdata_vld = !oe_n && !sleep;
  assign rdata     = rdata_vld ? rd_q : '0;

  p_cpu_capture_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep && !cpu_stb_n && !ce_n) |=> eff == $past(addr));

  p_ctl_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep && !ctl_stb_n && (cpu_stb_n || ce_n)) |=> eff == $past(addr));

  p_ce_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep && !cpu_stb_n && ce_n && ctl_stb_n && adv_n) |=> $stable(eff));

  p_burst_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep && (cpu_stb_n || ce_n) && ctl_stb_n && !adv_n) |=>
      (eff[1:0] == $past(eff[1:0]) + 2'd1) && (eff[AW-1:2] == $past(eff[AW-1:2])));

  p_sleep_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |=> $stable(eff) && $stable(rd_q));

  p_sleep_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |-> !rdata_vld && rdata == '0);

  p_oe_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> !rdata_vld && rdata == '0);
endmodule

// File: tb/burst_sram_tb.sv
module burst_sram_tb_top;
  localparam int AW = 6;
  localparam int DW = 8;
  localparam int DEPTH = 1 << AW;

  logic clk = 0, rst_n = 0;
  logic cpu_stb_n = 1, ctl_stb_n = 1, ce_n = 1, adv_n = 1, we_n = 1, oe_n = 1, sleep = 0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0, rdata;
  logic rdata_vld;

  int checks = 0, fails = 0;
  logic [DW-1:0] ref_mem [DEPTH];
  logic [AW-1:0] ref_eff;
  logic [DW-1:0] ref_rd;

  always #5 clk = ~clk;

  burst_sram #(.AW(AW), .DW(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .cpu_stb_n(cpu_stb_n), .ctl_stb_n(ctl_stb_n),
    .ce_n(ce_n), .adv_n(adv_n), .we_n(we_n), .oe_n(oe_n), .sleep(sleep),
    .addr(addr), .wdata(wdata), .rdata(rdata), .rdata_vld(rdata_vld));

  task automatic check(input string tag, input logic [DW:0] act, input logic [DW:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual vld/data=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input string tag, input logic c_n, input logic k_n, input logic e_n,
                      input logic a_n, input logic w_n, input logic o_n, input logic slp,
                      input logic [AW-1:0] a, input logic [DW-1:0] d);
    logic cpu_t, ctl_t, adv_t, ev;
    logic [AW-1:0] ne;
    logic [DW-1:0] nr;
    @(negedge clk);
    cpu_stb_n = c_n; ctl_stb_n = k_n; ce_n = e_n; adv_n = a_n;
    we_n = w_n; oe_n = o_n; sleep = slp; addr = a; wdata = d;
    @(posedge clk);
    if (!slp) begin
      cpu_t = !c_n && !e_n;
      ctl_t = !k_n && !cpu_t;
      adv_t = !cpu_t && !ctl_t && !a_n;
      nr = ref_mem[ref_eff];
      if (cpu_t || ctl_t) ne = a;
      else if (adv_t) ne = {ref_eff[AW-1:2], ref_eff[1:0] + 2'd1};
      else ne = ref_eff;
      if (!w_n && (ctl_t || adv_t)) ref_mem[ne] = d;
      ref_rd = nr;
      ref_eff = ne;
    end
    #1;
    ev = !o_n && !slp;
    check(tag, {rdata_vld, rdata}, {ev, ev ? ref_rd : {DW{1'b0}}});
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    ref_eff = '0; ref_rd = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1 check("R10 reset oe off", {rdata_vld, rdata}, '0);
    oe_n = 0;
    #1 check("R10 R8 reset read register", {rdata_vld, rdata}, {1'b1, {DW{1'b0}}});

    // R2 R4 R7: fill through the controller strobe, chip enable alternating
    for (int a = 0; a < DEPTH; a++)
      step("R2 R7 fill", 1, 0, a[0], 1, 0, 1, 0, a[AW-1:0], DW'(a * 7 + 3));

    // R1 R6: read sweep through the processor strobe
    for (int a = 0; a < DEPTH; a++)
      step("R1 R6 read", 0, 1, 0, 1, 1, 0, 0, a[AW-1:0], 8'h00);
    step("R6 pipeline tail", 1, 1, 0, 1, 1, 0, 0, '0, 8'h00);

    // R5: bursts from every start offset, five beats to show the wrap
    for (int a = 0; a < DEPTH; a += 3) begin
      step("R5 burst start", 1, 0, 1, 1, 1, 0, 0, a[AW-1:0], 8'h00);
      for (int b = 0; b < 5; b++)
        step("R5 burst beat", 1, 1, 1, 0, 1, 0, 0, '0, 8'h00);
    end

    // R7: burst writes then burst read-back
    for (int a = 1; a < DEPTH; a += 5) begin
      step("R7 burst write", 1, 0, 0, 1, 0, 1, 0, a[AW-1:0], DW'(a ^ 8'hA5));
      for (int b = 0; b < 3; b++)
        step("R7 burst write beat", 1, 1, 0, 0, 0, 1, 0, '0, DW'(a * 3 + b));
      step("R7 readback start", 0, 1, 0, 1, 1, 0, 0, a[AW-1:0], 8'h00);
      for (int b = 0; b < 4; b++)
        step("R7 readback beat", 1, 1, 0, 0, 1, 0, 0, '0, 8'h00);
    end

    // R3: both strobes low with chip enable on, write requested
    step("R3 both strobes", 0, 0, 0, 1, 0, 0, 0, 6'd9, 8'hEE);
    step("R3 no write", 0, 1, 0, 1, 1, 0, 0, 6'd9, 8'h00);
    step("R3 read back", 1, 1, 0, 1, 1, 0, 0, '0, 8'h00);

    // R4: processor strobe with chip enable off
    step("R4 select", 0, 1, 0, 1, 1, 0, 0, 6'd20, 8'h00);
    step("R4 ignored", 0, 1, 1, 1, 1, 0, 0, 6'd40, 8'h00);
    step("R4 held", 1, 1, 1, 1, 1, 0, 0, '0, 8'h00);
    step("R4 ctl acts", 0, 0, 1, 1, 0, 0, 0, 6'd41, 8'h5C);
    step("R4 ctl read", 1, 0, 1, 1, 1, 0, 0, 6'd41, 8'h00);
    step("R4 ctl data", 1, 1, 1, 1, 1, 0, 0, '0, 8'h00);

    // R7: idle edge with write enable low writes nothing
    step("R7 idle write", 1, 1, 0, 1, 0, 0, 0, '0, 8'h77);
    step("R7 idle check", 1, 1, 0, 1, 1, 0, 0, '0, 8'h00);

    // R8: output enable toggling
    for (int b = 0; b < 4; b++)
      step("R8 oe toggle", 1, 1, 0, 1, 1, b[0], 0, '0, 8'h00);

    // R9: sleep ignores everything, then resumes
    step("R9 pre-sleep select", 1, 0, 0, 1, 1, 0, 0, 6'd13, 8'h00);
    step("R9 sleep write", 1, 0, 0, 1, 0, 0, 1, 6'd13, 8'h99);
    step("R9 sleep adv", 1, 1, 0, 0, 0, 0, 1, '0, 8'h98);
    step("R9 sleep cpu", 0, 1, 0, 1, 1, 0, 1, 6'd50, 8'h00);
    step("R9 wake adv", 1, 1, 0, 0, 1, 0, 0, '0, 8'h00);
    step("R9 wake data", 1, 1, 0, 1, 1, 0, 0, '0, 8'h00);
    step("R9 wake read 13", 0, 1, 0, 1, 1, 0, 0, 6'd13, 8'h00);
    step("R9 retained", 1, 1, 0, 1, 1, 0, 0, '0, 8'h00);

    summary();
    $finish;
  end
endmodule